// File: doc/BRIEF.md
# Scatter-Gather Transmit Descriptor Walker

The walker is the transmit half of a scatter-gather DMA channel. Control logic elsewhere loads a starting descriptor address and a tail address, then pulses a start request. The walker follows a linked list of descriptors held in memory. For each one it fetches the fields it needs, streams the referenced buffer out as 32-bit beats on an AXI4-Stream master, and writes a status word back into the descriptor. It then follows the link to the next descriptor.

The walk ends in one of two ways. Either the descriptor just finished was the tail, or a freshly fetched descriptor already carries its completion mark. Either way the walker reports idle. Descriptors flagged as frame starts supply a set of sideband words for the frame. Descriptors flagged as frame ends close the stream packet with TLAST and produce a one-cycle completion pulse. Memory is reached through a simple single-word request/acknowledge port that carries one access at a time.

Top module: `sg_desc_walker`

## Requirements
- R1: After reset, `idle` is 1, `busy` is 0, `cur_ptr` is 0, and `mem_req`, `m_tvalid` and `frame_done` are all 0.
- R2: `ptr_load` copies `ptr_in` into `cur_ptr` while `busy` is 0. While `busy` is 1, `ptr_load` has no effect.
- R3: A walk begins only when `start` and `run` are both 1 in the same cycle and the walker is not busy. A `start` with `run` at 0 is ignored: no memory request is made and `idle` stays 1.
- R4: The descriptor fields are read at these byte offsets from the descriptor address: link at +0x00, buffer address at +0x08, control at +0x18, status at +0x1C. Only the low 32-bit word of each 64-bit pointer is used. Control carries the length in bits 22:0, end-of-frame in bit 26 and start-of-frame in bit 27. A memory request holds its address and direction until it is acknowledged.
- R5: A fetched descriptor whose status bit 31 is 1 stops the walk at once. No beats are sent, nothing is written, `cur_ptr` keeps that descriptor's address, and `idle` becomes 1.
- R6: A descriptor of length L yields ceil(L/4) beats, read from ascending word addresses that start at the (word-aligned) buffer address. Byte k of a word travels on `m_tdata[8k+7:8k]`. `m_tkeep` has all four bits set except on the last beat, where it keeps only the low (L mod 4) bytes. While `m_tvalid` is 1 and `m_tready` is 0, the beat is held unchanged and no memory request is made. A zero-length descriptor sends no beats.
- R7: `m_tlast` is 1 only on the final beat of an end-of-frame descriptor.
- R8: On a start-of-frame descriptor, the words at +0x20, +0x24, ... +0x34 are captured into `frame_app`, with word j placed at bits 32j+31:32j. They stay there until the next start-of-frame descriptor.
- R9: After its beats, each processed descriptor has the value 0x8000_0000 | L written to its status word at +0x1C.
- R10: Each processed end-of-frame descriptor produces exactly one single-cycle `frame_done` pulse, after its status write.
- R11: After the status write, `cur_ptr` takes the link value. If the descriptor was at `tail_ptr`, `idle` becomes 1 and `busy` falls. Otherwise the next descriptor is fetched. While `idle` is 1, no request or beat is issued.
- R12: A qualified start that arrives while busy is remembered. When the walk next stops, it starts again from `cur_ptr` without returning to idle.
- R13: If `run` is 0 when a descriptor finishes, the walker stops after advancing `cur_ptr`, with `busy` 0 and `idle` still 0. A later start resumes from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Channel running |
| start | input | 1 | Walk request pulse (tail updated) |
| ptr_load | input | 1 | Load current descriptor pointer |
| ptr_in | input | AW | Value for ptr_load |
| tail_ptr | input | AW | Address of the last descriptor to process |
| cur_ptr | output | AW | Current descriptor address |
| busy | output | 1 | Walk in progress |
| idle | output | 1 | Walk ended at tail or at a completed descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |
| m_tdata | output | 32 | Stream data |
| m_tkeep | output | 4 | Valid byte mask |
| m_tlast | output | 1 | Last beat of frame |
| frame_app | output | APP_N*32 | Sideband words of the current frame |
| frame_done | output | 1 | One-cycle pulse per finished frame |

## Verification
The bound assertions check these properties on every cycle:
- a stalled beat stays frozen, and memory stays silent while a beat waits;
- `m_tkeep` is always a contiguous low-byte mask;
- a pending memory request keeps its address and direction until acknowledged;
- every write carries the completion bit with a clean length field;
- `frame_done` never lasts two cycles, an idle walker issues nothing, and busy only rises after a qualified start.

Other behaviours need the bench's scenarios, which compare against a software walk of the same memory image. These are the byte order and keep of each beat, where TLAST falls, which descriptors get walked, the value written back, the final pointer, the captured sideband, and the latched-start and run-drop endings.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
    localparam int WORD_W   = 32;
    localparam int BYTES    = WORD_W / 8;
    localparam int LEN_W    = 23;
    localparam int EOF_BIT  = 26;
    localparam int SOF_BIT  = 27;
    localparam int DONE_BIT = 31;

    localparam int OFS_LINK = 'h00;
    localparam int OFS_BUF  = 'h08;
    localparam int OFS_CTRL = 'h18;
    localparam int OFS_STAT = 'h1C;
    localparam int OFS_APP  = 'h20;

    typedef enum logic [3:0] {
        ST_IDLE, ST_LINK, ST_BUF, ST_CTRL, ST_STAT,
        ST_APP, ST_RD, ST_OUT, ST_WB, ST_ADV
    } walk_st_e;
endpackage

// File: rtl/sgw_keep_gen.sv
module sgw_keep_gen #(
    parameter int LEN_W = 23,
    parameter int BYTES = 4
) (
    input  logic [LEN_W-1:0] rem,
    output logic [BYTES-1:0] keep,
    output logic             final_beat
);
    for (genvar i = 0; i < BYTES; i++) begin : g_keep
        assign keep[i] = (rem > LEN_W'(i));
    end
    assign final_beat = (rem <= LEN_W'(BYTES));
endmodule

// File: rtl/sgw_app_regs.sv
module sgw_app_regs #(
    parameter int APP_N  = 6,
    parameter int IDX_W  = 3,
    parameter int WORD_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_W-1:0]       wdata,
    output logic [APP_N*WORD_W-1:0] app
);
    for (genvar i = 0; i < APP_N; i++) begin : g_word
        logic [WORD_W-1:0] word_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && idx == IDX_W'(i))
                word_q <= wdata;
        end
        assign app[i*WORD_W +: WORD_W] = word_q;
    end
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
    parameter int AW    = 32,
    parameter int APP_N = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            start,
    input  logic                            ptr_load,
    input  logic [AW-1:0]                   ptr_in,
    input  logic [AW-1:0]                   tail_ptr,
    output logic [AW-1:0]                   cur_ptr,
    output logic                            busy,
    output logic                            idle,
    output logic                            mem_req,
    output logic                            mem_we,
    output logic [AW-1:0]                   mem_addr,
    output logic [sgw_pkg::WORD_W-1:0]      mem_wdata,
    input  logic                            mem_ack,
    input  logic [sgw_pkg::WORD_W-1:0]      mem_rdata,
    output logic                            m_tvalid,
    input  logic                            m_tready,
    output logic [sgw_pkg::WORD_W-1:0]      m_tdata,
    output logic [sgw_pkg::BYTES-1:0]       m_tkeep,
    output logic                            m_tlast,
    output logic [APP_N*sgw_pkg::WORD_W-1:0] frame_app,
    output logic                            frame_done
);
    import sgw_pkg::*;

    localparam int IDX_W = (APP_N > 1) ? $clog2(APP_N) : 1;

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     cur;
        logic [AW-1:0]     link;
        logic [AW-1:0]     baddr;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
        logic              sof;
        logic              eof;
        logic [IDX_W-1:0]  idx;
        logic              idle;
        logic              pend;
        logic [WORD_W-1:0] data;
        logic [BYTES-1:0]  keep;
        logic              last;
        logic              done;
    } walk_s;

    walk_s q, d;
    logic [BYTES-1:0] keep_w;
    logic             fin_w;
    logic             again;
    logic             app_we;

    sgw_keep_gen #(.LEN_W(LEN_W), .BYTES(BYTES)) u_keep (
        .rem(q.rem), .keep(keep_w), .final_beat(fin_w)
    );

    assign app_we = (q.st == ST_APP) && mem_ack;

    sgw_app_regs #(.APP_N(APP_N), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_app (
        .clk(clk), .rst_n(rst_n), .we(app_we), .idx(q.idx),
        .wdata(mem_rdata), .app(frame_app)
    );

    assign again = q.pend || (start && run);

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (q.st != ST_IDLE && start && run)
            d.pend = 1'b1;
        case (q.st)
            ST_IDLE: begin
                if (ptr_load)
                    d.cur = ptr_in;
                if (start && run) begin
                    d.idle = 1'b0;
                    d.st   = ST_LINK;
                end
            end
            ST_LINK: if (mem_ack) begin
                d.link = mem_rdata[AW-1:0];
                d.st   = ST_BUF;
            end
            ST_BUF: if (mem_ack) begin
                d.baddr = mem_rdata[AW-1:0];
                d.st    = ST_CTRL;
            end
            ST_CTRL: if (mem_ack) begin
                d.len = mem_rdata[LEN_W-1:0];
                d.rem = mem_rdata[LEN_W-1:0];
                d.sof = mem_rdata[SOF_BIT];
                d.eof = mem_rdata[EOF_BIT];
                d.st  = ST_STAT;
            end
            ST_STAT: if (mem_ack) begin
                if (mem_rdata[DONE_BIT]) begin
                    d.pend = 1'b0;
                    d.idle = !again;
                    d.st   = again ? ST_LINK : ST_IDLE;
                end else if (q.sof) begin
                    d.idx = '0;
                    d.st  = ST_APP;
                end else begin
                    d.st = (q.len == '0) ? ST_WB : ST_RD;
                end
            end
            ST_APP: if (mem_ack) begin
                if (q.idx == IDX_W'(APP_N - 1))
                    d.st = (q.len == '0) ? ST_WB : ST_RD;
                else
                    d.idx = q.idx + 1'b1;
            end
            ST_RD: if (mem_ack) begin
                d.data = mem_rdata;
                d.keep = keep_w;
                d.last = q.eof && fin_w;
                d.st   = ST_OUT;
            end
            ST_OUT: if (m_tready) begin
                d.baddr = q.baddr + AW'(BYTES);
                d.rem   = fin_w ? '0 : q.rem - LEN_W'(BYTES);
                d.st    = fin_w ? ST_WB : ST_RD;
            end
            ST_WB: if (mem_ack) begin
                d.done = q.eof;
                d.st   = ST_ADV;
            end
            ST_ADV: begin
                d.cur = q.link;
                if (q.cur == tail_ptr) begin
                    d.pend = 1'b0;
                    d.idle = !again;
                    d.st   = again ? ST_LINK : ST_IDLE;
                end else if (!run) begin
                    d.pend = 1'b0;
                    d.st   = ST_IDLE;
                end else begin
                    d.st = ST_LINK;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.idle <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        mem_addr = q.cur;
        case (q.st)
            ST_LINK: mem_addr = q.cur + AW'(OFS_LINK);
            ST_BUF:  mem_addr = q.cur + AW'(OFS_BUF);
            ST_CTRL: mem_addr = q.cur + AW'(OFS_CTRL);
            ST_STAT: mem_addr = q.cur + AW'(OFS_STAT);
            ST_APP:  mem_addr = q.cur + AW'(OFS_APP) + AW'({q.idx, 2'b00});
            ST_RD:   mem_addr = q.baddr;
            ST_WB:   mem_addr = q.cur + AW'(OFS_STAT);
            default: mem_addr = q.cur;
        endcase
    end

    assign mem_req   = q.st inside {ST_LINK, ST_BUF, ST_CTRL, ST_STAT, ST_APP, ST_RD, ST_WB};
    assign mem_we    = (q.st == ST_WB);
    assign mem_wdata = {1'b1, {(WORD_W-1-LEN_W){1'b0}}, q.len};
    assign m_tvalid  = (q.st == ST_OUT);
    assign m_tdata   = q.data;
    assign m_tkeep   = q.keep;
    assign m_tlast   = q.last;
    assign busy      = (q.st != ST_IDLE);
    assign idle      = q.idle;
    assign cur_ptr   = q.cur;
    assign frame_done = q.done;
endmodule

// File: rtl/sg_desc_walker_chk.sv
module sg_desc_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          start,
    input logic          busy,
    input logic          idle,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          m_tvalid,
    input logic          m_tready,
    input logic [31:0]   m_tdata,
    input logic [3:0]    m_tkeep,
    input logic          m_tlast,
    input logic          frame_done
);
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep) && $stable(m_tlast)); // R6
    AST_NO_READ_IN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> !mem_req); // R6
    AST_KEEP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        m_tvalid |-> (m_tkeep == 4'h1 || m_tkeep == 4'h3 || m_tkeep == 4'h7 || m_tkeep == 4'hF)); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R4
    AST_WB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_wdata[31] && (mem_wdata[30:23] == 8'h00)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !busy && !mem_req && !m_tvalid); // R11
    AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(run) && $past(start)); // R3
endmodule

bind sg_desc_walker sg_desc_walker_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .start(start), .busy(busy), .idle(idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .frame_done(frame_done)
);

// File: tb/sg_desc_walker_test.sv
module sg_desc_walker_test;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0, run = 1'b0, start = 1'b0, ptr_load = 1'b0;
    logic [31:0] ptr_in = '0, tail_ptr = '0, cur_ptr;
    logic        busy, idle, mem_req, mem_we, mem_ack = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic        m_tvalid, m_tready = 1'b0, m_tlast, frame_done;
    logic [31:0] m_tdata;
    logic [3:0]  m_tkeep;
    logic [191:0] frame_app;

    sg_desc_walker uut (
        .clk(clk), .rst_n(rst_n), .run(run), .start(start), .ptr_load(ptr_load),
        .ptr_in(ptr_in), .tail_ptr(tail_ptr), .cur_ptr(cur_ptr), .busy(busy), .idle(idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast), .frame_app(frame_app),
        .frame_done(frame_done)
    );

    logic [31:0] mem [0:1023];
    int total = 0, bad = 0, cyc = 0;
    logic [31:0] e_data [0:511];
    logic [3:0]  e_keep [0:511];
    logic        e_last [0:511];
    logic [31:0] wb_addr [0:63];
    logic [31:0] wb_val [0:63];
    logic [31:0] e_app [0:5];
    int e_n, r_n, e_done, r_done, wb_n, reqs;
    bit app_seen, rdy_rand;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem[a[11:2]];
    endfunction

    function automatic logic [31:0] pat(logic [31:0] a);
        return (a * 32'h0100_0193) ^ 32'h5A3C_96E1;
    endfunction

    // Bench memory and stream sink: decisions made at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            m_tready = rdy_rand ? ($urandom % 3 != 0) : 1'b1;
            mem_ack  = mem_req && ($urandom % 2 == 0);
            if (mem_req) reqs++;
            if (mem_ack) begin
                if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                else        mem_rdata = mem[mem_addr[11:2]];
            end
            if (m_tvalid && m_tready) begin
                if (r_n < e_n) begin
                    logic [31:0] msk;
                    for (int b = 0; b < 4; b++) msk[8*b +: 8] = {8{e_keep[r_n][b]}};
                    chk("R6 beat data", m_tdata & msk, e_data[r_n] & msk);
                    chk("R6 beat keep", {28'd0, m_tkeep}, {28'd0, e_keep[r_n]});
                    chk("R7 beat last", {31'd0, m_tlast}, {31'd0, e_last[r_n]});
                end else begin
                    chk("R6 extra beat", r_n, e_n - 1);
                end
                r_n++;
            end
            if (frame_done) r_done++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements actual=%0d expected<%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic clr();
        e_n = 0; r_n = 0; e_done = 0; r_done = 0; wb_n = 0; reqs = 0; app_seen = 0;
    endtask

    task automatic mk_desc(logic [31:0] a, logic [31:0] nxt, logic [31:0] b, int len,
                           bit sof, bit eof, bit done);
        mem[(a + 32'h00) >> 2] = nxt;
        mem[(a + 32'h04) >> 2] = 32'hDEAD_0001;
        mem[(a + 32'h08) >> 2] = b;
        mem[(a + 32'h0C) >> 2] = 32'hDEAD_0002;
        mem[(a + 32'h18) >> 2] = {4'b0, sof, eof, 3'b0, 23'(len)};
        mem[(a + 32'h1C) >> 2] = done ? 32'h8000_0000 : 32'h0;
        for (int j = 0; j < 6; j++) mem[(a + 32'h20 + 4*j) >> 2] = pat(a + 32'h100 + j);
        for (int j = 0; j < 8; j++) mem[(b + 4*j) >> 2] = pat(b + 4*j);
    endtask

    task automatic model_walk(logic [31:0] p0, logic [31:0] tail, int maxd,
                              output logic [31:0] fp, output bit fi);
        logic [31:0] p = p0, ctl, b;
        int len, nb, rem;
        fp = p0; fi = 0;
        for (int k = 0; k < maxd; k++) begin
            if (rd(p + 32'h1C) & 32'h8000_0000) begin fp = p; fi = 1; return; end
            ctl = rd(p + 32'h18); len = int'(ctl[22:0]); b = rd(p + 32'h08);
            if (ctl[27]) begin
                app_seen = 1;
                for (int j = 0; j < 6; j++) e_app[j] = rd(p + 32'h20 + 4*j);
            end
            nb = (len + 3) / 4;
            for (int j = 0; j < nb; j++) begin
                rem = len - 4*j;
                e_data[e_n] = rd(b + 4*j);
                e_keep[e_n] = (rem >= 4) ? 4'hF : 4'((1 << rem) - 1);
                e_last[e_n] = ctl[26] && (j == nb - 1);
                e_n++;
            end
            if (ctl[26]) e_done++;
            wb_addr[wb_n] = p + 32'h1C; wb_val[wb_n] = 32'h8000_0000 | 32'(len); wb_n++;
            if (p == tail) begin fp = rd(p); fi = 1; return; end
            p = rd(p);
            fp = p;
        end
    endtask

    task automatic pulse_load(logic [31:0] v);
        @(negedge clk); ptr_in = v; ptr_load = 1'b1;
        @(negedge clk); ptr_load = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_stop(string req);
        int n = 0;
        while (busy && n < 20000) begin @(negedge clk); n++; end
        if (n >= 20000) chk({req, " walk ends"}, 32'(busy), 32'd0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_end(string tag, logic [31:0] fp, bit fi);
        chk({tag, " R6 beat count"}, r_n, e_n);
        chk({tag, " R10 frame_done count"}, r_done, e_done);
        chk({tag, " R11 cur_ptr"}, cur_ptr, fp);
        chk({tag, " R11 idle"}, {31'd0, idle}, {31'd0, fi});
        for (int k = 0; k < wb_n; k++) chk({tag, " R9 status write"}, rd(wb_addr[k]), wb_val[k]);
        if (app_seen)
            for (int j = 0; j < 6; j++) chk({tag, " R8 sideband"}, frame_app[32*j +: 32], e_app[j]);
    endtask

    initial begin
        logic [31:0] fp, fp2;
        bit fi, fi2;
        int n1;
        void'($urandom(32'd2024));
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        clr();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 idle", {31'd0, idle}, 32'd1);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 cur_ptr", cur_ptr, 32'd0);
        chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk("R1 tvalid", {31'd0, m_tvalid}, 32'd0);
        chk("R1 frame_done", {31'd0, frame_done}, 32'd0);

        // R3 start without run is ignored
        mk_desc(32'h100, 32'h140, 32'h800, 8, 1, 1, 0);
        pulse_load(32'h100);
        chk("R2 load while stopped", cur_ptr, 32'h100);
        tail_ptr = 32'h100;
        pulse_start();
        repeat (20) @(negedge clk);
        chk("R3 no request without run", reqs, 0);
        chk("R3 idle kept", {31'd0, idle}, 32'd1);

        // Directed three-descriptor frame; ptr_load during walk (R2)
        clr();
        mk_desc(32'h100, 32'h140, 32'h800, 10, 1, 0, 0);
        mk_desc(32'h140, 32'h180, 32'h840, 4, 0, 0, 0);
        mk_desc(32'h180, 32'h1C0, 32'h880, 7, 0, 1, 0);
        tail_ptr = 32'h180;
        model_walk(32'h100, 32'h180, 8, fp, fi);
        chk("R6 model beat total", e_n, 6);
        rdy_rand = 1; run = 1'b1;
        pulse_start();
        repeat (5) @(negedge clk);
        ptr_in = 32'h3F0; ptr_load = 1'b1;
        @(negedge clk); ptr_load = 1'b0;
        wait_stop("directed");
        check_end("directed R2", fp, fi);
        chk("R2 load ignored while busy", cur_ptr, 32'h1C0);

        // R5 already-complete descriptor
        clr();
        mk_desc(32'h200, 32'h240, 32'h900, 12, 1, 1, 1);
        pulse_load(32'h200);
        tail_ptr = 32'h300;
        pulse_start();
        wait_stop("R5");
        chk("R5 no beats", r_n, 0);
        chk("R5 status untouched", rd(32'h21C), 32'h8000_0000);
        chk("R5 cur_ptr kept", cur_ptr, 32'h200);
        chk("R5 idle", {31'd0, idle}, 32'd1);

        // Random chains
        for (int it = 0; it < 6; it++) begin
            int n;
            bit sof;
            clr();
            n = 2 + int'($urandom % 5);
            sof = 1;
            for (int k = 0; k < n; k++) begin
                bit eof = (k == n - 1) || ($urandom % 3 == 0);
                mk_desc(32'(k * 'h40), (k == n - 1) ? 32'h3C0 : 32'((k + 1) * 'h40),
                        32'h800 + 32'(k * 'h40), int'($urandom % 25), sof, eof, 0);
                sof = eof;
            end
            tail_ptr = 32'((n - 1) * 'h40);
            model_walk(32'h0, tail_ptr, 16, fp, fi);
            pulse_load(32'h0);
            pulse_start();
            wait_stop("random");
            check_end("random R4 R7", fp, fi);
        end

        // R12 start while busy is latched
        clr();
        mk_desc(32'h100, 32'h140, 32'h800, 6, 1, 0, 0);
        mk_desc(32'h140, 32'h180, 32'h840, 3, 0, 1, 0);
        mk_desc(32'h180, 32'h1C0, 32'h880, 9, 1, 1, 0);
        mk_desc(32'h1C0, 32'h200, 32'h8C0, 4, 1, 1, 1);
        tail_ptr = 32'h140;
        model_walk(32'h100, 32'h140, 8, fp, fi);
        model_walk(fp, 32'h140, 8, fp2, fi2);
        pulse_load(32'h100);
        pulse_start();
        repeat (3) @(negedge clk);
        pulse_start();
        wait_stop("R12");
        check_end("R12", fp2, fi2);

        // R13 run dropped mid-walk
        clr();
        mk_desc(32'h100, 32'h140, 32'h800, 8, 1, 0, 0);
        mk_desc(32'h140, 32'h180, 32'h840, 4, 0, 0, 0);
        mk_desc(32'h180, 32'h1C0, 32'h880, 5, 0, 1, 0);
        tail_ptr = 32'h180;
        model_walk(32'h100, 32'h180, 1, fp, fi);
        n1 = e_n;
        model_walk(fp, 32'h180, 8, fp2, fi2);
        pulse_load(32'h100);
        pulse_start();
        run = 1'b0;
        wait_stop("R13");
        chk("R13 beats before stop", r_n, n1);
        chk("R13 busy low", {31'd0, busy}, 32'd0);
        chk("R13 idle stays low", {31'd0, idle}, 32'd0);
        chk("R13 cur_ptr advanced", cur_ptr, fp);
        run = 1'b1;
        pulse_start();
        wait_stop("R13 resume");
        check_end("R13 resume", fp2, fi2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule